// File: doc/BRIEF.md
# Binary to Modulo 2^N+1 Residue Converter

This block converts a K-bit unsigned binary word into its residue modulo 2^N+1. It is the front end of a residue-number datapath: each input word enters the modulo 2^N+1 channel through it. The input is cut into N-bit slices from the least significant end, and a short top slice is filled with zeros. Every odd-numbered slice is bit-inverted. This works because a negated slice equals its complement plus two in this modulus. A constant correction is then added. A carry-save chain whose carries wrap round inverted at the top reduces the slices to two N-bit addends. A two-operand adder that adds its inverted carry back in turns those two addends into the (N+1)-bit weighted residue.

The correction constant is worked out during elaboration from K and N. It is already reduced by one, because the final adder adds one of its own. When the result is wanted in diminished-1 form, it is reduced by two. A run-time mode input selects one of the two constants. The correction stage sits at the end of the chain. When the selected constant works out to 2^N, that stage is bypassed and its inputs go straight to the final adder. In diminished-1 form, the low N bits hold the residue minus one and the top bit flags a zero residue. The result is registered. It needs K > N and N >= 2.

Top module: `rg_residue_gen`

## Requirements
- R1: While the synchronous active-high reset is high at a rising edge, the result register becomes all zeros.
- R2: The result for the word and mode present at a rising edge appears after that edge, so a new input shows up one cycle later.
- R3: With mode 0 (weighted), the result equals din mod (2^N+1). Bit N is set only for the value 2^N, and then the low N bits are zero.
- R4: With mode 1 (diminished-1) and a nonzero residue r, bit N is 0 and the low N bits equal r-1.
- R5: With mode 1 and a zero residue, the result is a 1 in bit N followed by N zero bits.
- R6: When K is not a multiple of N, the short top slice is zero-padded and still handled correctly. For K=10, N=3, din=1023 gives 6 weighted and 5 diminished-1.
- R7: A residue of 2^N is produced in full. For N=3, din=143 gives 1000 in binary weighted and 0111 diminished-1.
- R8: When the selected correction reduces to 2^N, the correction stage is bypassed and every result stays correct. K=9, N=3 in weighted mode is such a case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | K | Unsigned binary word to convert |
| dim_mode | input | 1 | 0: weighted result, 1: diminished-1 result with zero flag |
| res_q | output | N+1 | Registered residue (weighted) or {zero flag, residue-1} |

## Verification
The assertions compare every registered result with an arithmetic reference, in both output forms and on every cycle after reset. They also check that bit N never appears together with nonzero low bits, and that reset clears the result. Other behaviour shows only in the bench's scenarios. This covers the one-cycle latency after an input change and results for a mode switch between consecutive words. It also covers the bypass of the correction stage, which only the K=9 configuration reaches, and the named corner words 0, 143 and all-ones. The bench sweeps every input word in both modes for two configurations, one with a padded top slice and one with a bypassed correction.

// File: rtl/rg_pkg.sv
package rg_pkg;

  // Number of N-bit slices covering a K-bit word.
  function automatic int rg_groups(input int k, input int n);
    return (k + n - 1) / n;
  endfunction

  // Correction constant, already reduced modulo 2^n+1.
  // dim = 0: weighted output, dim = 1: diminished-1 output.
  // A return value of 2^n means the correction stage is bypassed.
  function automatic int rg_corr(input int k, input int n, input int dim);
    int q;
    int modv;
    int acc;
    int real_bits;
    q    = (k + n - 1) / n;
    modv = (1 << n) + 1;
    acc  = 0;
    for (int i = 0; i < q; i++) begin
      if ((i % 2) == 1) begin
        acc += 2;
        real_bits = k - i * n;
        if (real_bits < n) acc += (1 << n) - (1 << real_bits);
      end
    end
    // The chain adds one per stage; the final adder adds one.
    acc = acc - q - dim;
    acc = acc % modv;
    if (acc < 0) acc += modv;
    return acc;
  endfunction

endpackage

// File: rtl/rg_group_map.sv
module rg_group_map #(
  parameter int K = 10,
  parameter int N = 3,
  parameter int Q = 4
) (
  input  logic [K-1:0]   din,
  output logic [Q*N-1:0] ops_flat
);
  localparam int PADW = Q * N;

  logic [PADW-1:0] din_ext;
  assign din_ext = PADW'(din);

  for (genvar gi = 0; gi < Q; gi++) begin : g_slice
    localparam int LOW  = gi * N;
    localparam int REAL = ((K - LOW) < N) ? (K - LOW) : N;
    localparam logic [N-1:0] REAL_MASK = N'((64'd1 << REAL) - 64'd1);
    if ((gi % 2) == 1) begin : g_inv
      // Only real bits are inverted; padded bits stay zero.
      assign ops_flat[LOW +: N] = ~din_ext[LOW +: N] & REAL_MASK;
    end else begin : g_keep
      assign ops_flat[LOW +: N] = din_ext[LOW +: N];
    end
  end
endmodule

// File: rtl/rg_csa_eac.sv
module rg_csa_eac #(
  parameter int N = 3
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic [N-1:0] c,
  output logic [N-1:0] s,
  output logic [N-1:0] t
);
  logic [N-1:0] maj;

  assign s   = a ^ b ^ c;
  assign maj = (a & b) | (a & c) | (b & c);
  // The top carry wraps round inverted into bit 0.
  assign t   = {maj[N-2:0], ~maj[N-1]};
endmodule

// File: rtl/rg_csa_chain.sv
module rg_csa_chain #(
  parameter int N = 3,
  parameter int Q = 4
) (
  input  logic [Q*N-1:0] ops_flat,
  output logic [N-1:0]   x,
  output logic [N-1:0]   y
);
  logic [N-1:0] sv [0:Q-2];
  logic [N-1:0] tv [0:Q-2];

  assign sv[0] = ops_flat[0 +: N];
  assign tv[0] = ops_flat[N +: N];

  for (genvar j = 0; j < Q - 2; j++) begin : g_stage
    rg_csa_eac #(.N(N)) u_stage (
      .a (sv[j]),
      .b (tv[j]),
      .c (ops_flat[(j+2)*N +: N]),
      .s (sv[j+1]),
      .t (tv[j+1])
    );
  end

  assign x = sv[Q-2];
  assign y = tv[Q-2];
endmodule

// File: rtl/rg_mod_adder.sv
module rg_mod_adder #(
  parameter int N = 3
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  output logic [N:0]   res
);
  logic [N:0]   raw;
  logic [N-1:0] low;
  logic         top;

  assign raw = {1'b0, x} + {1'b0, y};
  // Inverted carry added back at the bottom: result is x+y+1 mod 2^N+1.
  assign low = raw[N-1:0] + {{(N-1){1'b0}}, ~raw[N]};
  // x and y bitwise complementary: all propagate, no generate.
  assign top = (&(x ^ y)) & ~raw[N];
  assign res = {top, low};
endmodule

// File: rtl/rg_residue_gen.sv
module rg_residue_gen #(
  parameter int K = 10,
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [K-1:0] din,
  input  logic         dim_mode,
  output logic [N:0]   res_q
);
  import rg_pkg::*;

  localparam int Q  = rg_groups(K, N);
  localparam int CW = rg_corr(K, N, 0);
  localparam int CD = rg_corr(K, N, 1);
  localparam logic [N-1:0] CW_BITS = N'(CW);
  localparam logic [N-1:0] CD_BITS = N'(CD);
  localparam bit SKIP_W = (CW == (1 << N));
  localparam bit SKIP_D = (CD == (1 << N));

  logic [Q*N-1:0] ops_flat;
  logic [N-1:0]   x0, y0, x1, y1, xf, yf, corr;
  logic           skip;
  logic [N:0]     res_d;

  rg_group_map #(.K(K), .N(N), .Q(Q)) u_map (
    .din      (din),
    .ops_flat (ops_flat)
  );

  rg_csa_chain #(.N(N), .Q(Q)) u_chain (
    .ops_flat (ops_flat),
    .x        (x0),
    .y        (y0)
  );

  assign corr = dim_mode ? CD_BITS : CW_BITS;
  assign skip = dim_mode ? SKIP_D  : SKIP_W;

  rg_csa_eac #(.N(N)) u_corr_stage (
    .a (x0),
    .b (y0),
    .c (corr),
    .s (x1),
    .t (y1)
  );

  assign xf = skip ? x0 : x1;
  assign yf = skip ? y0 : y1;

  rg_mod_adder #(.N(N)) u_final (
    .x   (xf),
    .y   (yf),
    .res (res_d)
  );

  always_ff @(posedge clk) begin
    if (rst) res_q <= '0;
    else     res_q <= res_d;
  end
endmodule

// File: rtl/rg_residue_gen_chk.sv
module rg_residue_gen_chk #(
  parameter int K = 10,
  parameter int N = 3
) (
  input logic         clk,
  input logic         rst,
  input logic [K-1:0] din,
  input logic         dim_mode,
  input logic [N:0]   res_q
);
  localparam longint unsigned MODV = (64'd1 << N) + 64'd1;

  logic         seen = 1'b0;
  logic         rst_d;
  logic         warm;
  logic [K-1:0] din_d;
  logic         mode_d;
  logic [63:0]  ref_r;

  always_ff @(posedge clk) begin
    seen   <= 1'b1;
    rst_d  <= rst;
    warm   <= !rst;
    din_d  <= din;
    mode_d <= dim_mode;
  end

  assign ref_r = 64'(din_d) % MODV;

  assert_reset_clear_R1: assert property (@(posedge clk)
    seen && rst_d |-> res_q == '0);

  assert_weighted_R3: assert property (@(posedge clk) disable iff (rst)
    warm && !mode_d |-> res_q == (N+1)'(ref_r));

  assert_top_bit_alone_R3: assert property (@(posedge clk) disable iff (rst)
    warm && res_q[N] |-> res_q[N-1:0] == '0);

  assert_dim_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    warm && mode_d && ref_r != 64'd0 |-> res_q == (N+1)'(ref_r - 64'd1));

  assert_dim_zero_R5: assert property (@(posedge clk) disable iff (rst)
    warm && mode_d && ref_r == 64'd0 |-> res_q == {1'b1, {N{1'b0}}});
endmodule

bind rg_residue_gen rg_residue_gen_chk #(.K(K), .N(N)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .din      (din),
  .dim_mode (dim_mode),
  .res_q    (res_q)
);

// File: tb/rg_residue_gen_bench.sv
module rg_residue_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MODV = 9;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] din_a = '0;
  logic [8:0] din_b = '0;
  logic       mode = 1'b0;
  logic [3:0] res_a, res_b;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rg_residue_gen u_rg_residue_gen (
    .clk (clk), .rst (rst), .din (din_a), .dim_mode (mode), .res_q (res_a)
  );

  rg_residue_gen #(.K(9), .N(3)) u_rg_residue_gen_b (
    .clk (clk), .rst (rst), .din (din_b), .dim_mode (mode), .res_q (res_b)
  );

  function automatic logic [3:0] model(input int a, input bit dim);
    int r;
    r = a % MODV;
    if (!dim) return 4'(r);
    if (r == 0) return 4'b1000;
    return 4'(r - 1);
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic apply(input int a, input bit dim);
    @(negedge clk);
    din_a = 10'(a);
    din_b = 9'(a);
    mode  = dim;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    din_a = 10'h3FF;
    din_b = 9'h1FF;
    repeat (3) @(negedge clk);
    check("R1 reset A", res_a, 4'b0000);
    check("R1 reset B", res_b, 4'b0000);
    rst = 1'b0;

    // R2: one-cycle latency on back-to-back words
    apply(5, 1'b0);
    check("R2 first word", res_a, model(5, 1'b0));
    @(negedge clk);
    din_a = 10'd13;
    mode  = 1'b1;
    @(negedge clk);
    check("R2 next word", res_a, model(13, 1'b1));

    // Named corner words
    apply(0, 1'b0);
    check("R3 zero weighted", res_a, 4'b0000);
    apply(0, 1'b1);
    check("R5 zero dim", res_a, 4'b1000);
    apply(1, 1'b1);
    check("R4 one dim", res_a, 4'b0000);
    apply(1023, 1'b0);
    check("R6 all-ones weighted", res_a, 4'd6);
    apply(1023, 1'b1);
    check("R6 all-ones dim", res_a, 4'd5);
    apply(143, 1'b0);
    check("R7 143 weighted A", res_a, 4'b1000);
    check("R7 143 weighted B", res_b, 4'b1000);
    apply(143, 1'b1);
    check("R7 143 dim A", res_a, 4'b0111);
    check("R7 143 dim B", res_b, 4'b0111);
    apply(511, 1'b0);
    check("R8 all-ones B weighted", res_b, 4'(511 % MODV));

    // Exhaustive sweep, modes alternating word by word
    for (int i = 0; i < 1024; i++) begin
      for (int m = 0; m < 2; m++) begin
        apply(i, m[0]);
        if (m == 0) check("R3 sweep", res_a, model(i, 1'b0));
        else if (i % MODV == 0) check("R5 sweep", res_a, model(i, 1'b1));
        else check("R4 sweep", res_a, model(i, 1'b1));
        if (i < 512) check("R8 sweep B", res_b, model(i, m[0]));
      end
    end

    // R1 again: reset mid-run clears a nonzero result
    apply(8, 1'b0);
    check("R3 eight", res_a, 4'b1000);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset mid-run", res_a, 4'b0000);
    rst = 1'b0;

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule